// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block keeps the exception-related state of a floating-point status register: a five-bit trap-enable mask, a five-bit accrued-exception field, a five-bit current-exception field and a three-bit trap-type field. All of them sit in one 32-bit word. The other bits of the word keep whatever software last wrote there. Each time an arithmetic operation completes, the datapath presents the five exception flags it raised together with an update strobe.

The recorder decides whether the operation traps. A trap occurs when any raised flag is also enabled. On a non-trapping update the flags are recorded as the current exceptions and merged into the accrued set. On a trapping update only the enabled flags count, and only the most severe of them is recorded. The accrued set is left alone, the trap-type field is loaded with the IEEE-exception code, and a one-cycle trap request goes to the pipeline.

Software can replace the whole word through a write port, and a separate pulse clears the trap-type field after the handler has run.

Top module: `fpx_status_recorder`

## Requirements
- R1: While reset is high and in the first cycle after it, `status_q` is all zeros and `trap_req` is 0.
- R2: Field positions in `status_q`. The trap-enable mask is at bits 27:23, the trap type at 16:14, the accrued exceptions at 9:5 and the current exceptions at 4:0. Within each five-bit field and in `upd_flags`: bit 4 is invalid, bit 3 is overflow, bit 2 is underflow, bit 1 is divide-by-zero and bit 0 is inexact.
- R3: An update traps exactly when `upd_flags & enable-mask` is non-zero. `trap_req` is then 1 in the cycle after the strobe, and 0 in the cycle after any strobe that does not trap. The register changes on the same clock edge that raises `trap_req`.
- R4: A non-trapping update with non-zero flags writes `upd_flags` into the current field, ORs them into the accrued field, and leaves the trap-type field unchanged.
- R5: A trapping update writes the current field with a single bit: the highest-priority bit of `upd_flags & enable-mask`, in the order invalid, overflow, underflow, divide-by-zero, inexact. The accrued field is unchanged.
- R6: A trapping update loads the trap-type field with 3'b001.
- R7: An update strobe with all-zero flags changes nothing in `status_q` and raises no trap.
- R8: When `wr_en` is high, the next `status_q` equals `wr_data` in all 32 bits. An update in the same cycle is discarded and raises no trap.
- R9: `clr_ttype` zeroes bits 16:14 on the next edge. A trapping update in the same cycle still leaves 3'b001. A software write overrides both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | An operation completed this cycle |
| upd_flags | input | 5 | Exception flags raised by that operation |
| clr_ttype | input | 1 | Clear the trap-type field |
| wr_en | input | 1 | Software write of the whole register |
| wr_data | input | 32 | Value written by software |
| status_q | output | 32 | Register contents |
| trap_req | output | 1 | One-cycle trap request |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it. That holds for the register fields and for `trap_req`. The bench drives inputs at the falling edge and steps its own reference model once per rising edge. It compares both outputs shortly after that rising edge, so each check covers precisely the one-cycle latency that R3 requires. Directed cycles exercise multiple enabled flags, zero-flag strobes and collisions of write, clear and update. Seeded random cycles then mix all of these inputs.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W = 5;
  localparam int REG_W  = 32;
  localparam int EN_LSB  = 23;
  localparam int TT_LSB  = 14;
  localparam int TT_W    = 3;
  localparam int ACC_LSB = 5;
  localparam int CUR_LSB = 0;
  // trap-type code meaning "IEEE exception"
  localparam logic [TT_W-1:0] TT_IEEE = 3'b001;
  // flag bit positions: invalid 4, overflow 3, underflow 2, divzero 1, inexact 0
  localparam int FX_INVALID  = 4;
  localparam int FX_INEXACT  = 0;
endpackage

// File: rtl/fpx_prio_pick.sv
// Keeps only the highest-index set bit of req (index W-1 is most severe).
module fpx_prio_pick #(
  parameter int W = 5
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] gnt
);
  logic [W:0] hit_at_or_above;

  assign hit_at_or_above[W] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_pick
    assign hit_at_or_above[i] = hit_at_or_above[i+1] | req[i];
    assign gnt[i]             = req[i] & ~hit_at_or_above[i+1];
  end
endmodule

// File: rtl/fpx_trap_eval.sv
// Combinational trap decision and current-field value for one update.
module fpx_trap_eval #(
  parameter int W = 5
) (
  input  logic [W-1:0] flags,
  input  logic [W-1:0] enables,
  output logic         trap,
  output logic [W-1:0] cur_next
);
  logic [W-1:0] armed;
  logic [W-1:0] single;

  assign armed = flags & enables;

  fpx_prio_pick #(.W(W)) u_pick (
    .req (armed),
    .gnt (single)
  );

  assign trap     = |armed;
  assign cur_next = trap ? single : flags;
endmodule

// File: rtl/fpx_status_reg.sv
// Holds the status word and the registered trap request.
module fpx_status_reg #(
  parameter int              REG_W   = 32,
  parameter int              FLAG_W  = 5,
  parameter int              ACC_LSB = 5,
  parameter int              CUR_LSB = 0,
  parameter int              TT_LSB  = 14,
  parameter int              TT_W    = 3,
  parameter logic [TT_W-1:0] TT_CODE = 3'b001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              clr_tt,
  input  logic              upd,
  input  logic [FLAG_W-1:0] flags,
  input  logic              trap,
  input  logic [FLAG_W-1:0] cur_next,
  output logic [REG_W-1:0]  status_q,
  output logic              trap_q
);
  logic [REG_W-1:0] nxt;
  logic             trap_d;

  always_comb begin
    nxt = status_q;
    if (clr_tt) nxt[TT_LSB +: TT_W] = '0;
    if (upd) begin
      nxt[CUR_LSB +: FLAG_W] = cur_next;
      if (trap) nxt[TT_LSB +: TT_W] = TT_CODE;
      else      nxt[ACC_LSB +: FLAG_W] = status_q[ACC_LSB +: FLAG_W] | flags;
    end
    if (wr_en) nxt = wr_data;
  end

  assign trap_d = upd & trap & ~wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      trap_q   <= 1'b0;
    end else begin
      status_q <= nxt;
      trap_q   <= trap_d;
    end
  end
endmodule

// File: rtl/fpx_status_recorder.sv
module fpx_status_recorder #(
  parameter int              FLAG_W  = fpx_pkg::FLAG_W,
  parameter int              REG_W   = fpx_pkg::REG_W,
  parameter int              EN_LSB  = fpx_pkg::EN_LSB,
  parameter int              ACC_LSB = fpx_pkg::ACC_LSB,
  parameter int              CUR_LSB = fpx_pkg::CUR_LSB,
  parameter int              TT_LSB  = fpx_pkg::TT_LSB,
  parameter int              TT_W    = fpx_pkg::TT_W,
  parameter logic [TT_W-1:0] TT_CODE = fpx_pkg::TT_IEEE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [FLAG_W-1:0] upd_flags,
  input  logic              clr_ttype,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  status_q,
  output logic              trap_req
);
  logic              upd_live;
  logic              trap;
  logic [FLAG_W-1:0] cur_next;

  // a strobe with no flags is a no-op
  assign upd_live = upd_valid & (|upd_flags);

  fpx_trap_eval #(.W(FLAG_W)) u_eval (
    .flags    (upd_flags),
    .enables  (status_q[EN_LSB +: FLAG_W]),
    .trap     (trap),
    .cur_next (cur_next)
  );

  fpx_status_reg #(
    .REG_W(REG_W), .FLAG_W(FLAG_W), .ACC_LSB(ACC_LSB), .CUR_LSB(CUR_LSB),
    .TT_LSB(TT_LSB), .TT_W(TT_W), .TT_CODE(TT_CODE)
  ) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .clr_tt   (clr_ttype),
    .upd      (upd_live),
    .flags    (upd_flags),
    .trap     (trap),
    .cur_next (cur_next),
    .status_q (status_q),
    .trap_q   (trap_req)
  );

  AST_ZERO_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_flags == '0 && !wr_en && !clr_ttype) |=> (!trap_req && $stable(status_q))); // R7
  AST_TRAP_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> ($countones(status_q[CUR_LSB +: FLAG_W]) == 1)); // R5
  AST_TRAP_KEEPS_ACCRUED: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (status_q[ACC_LSB +: FLAG_W] == $past(status_q[ACC_LSB +: FLAG_W]))); // R5
  AST_TRAP_TYPE_SET: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (status_q[TT_LSB +: TT_W] == TT_CODE)); // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (status_q == $past(wr_data) && !trap_req)); // R8
  AST_NO_TRAP_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> !trap_req); // R3
endmodule

// File: tb/sim_fpx_status_recorder.sv
module sim_fpx_status_recorder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_valid = 1'b0;
  logic [4:0]  upd_flags = '0;
  logic        clr_ttype = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] status_q;
  logic        trap_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [31:0] exp_reg = '0;
  logic        exp_trap = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  fpx_status_recorder u0 (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_flags(upd_flags),
    .clr_ttype(clr_ttype), .wr_en(wr_en), .wr_data(wr_data),
    .status_q(status_q), .trap_req(trap_req)
  );

  function automatic logic [4:0] top_bit(input logic [4:0] v);
    for (int i = 4; i >= 0; i--) if (v[i]) return 5'(1 << i);
    return 5'b0;
  endfunction

  task automatic check(input string tag);
    n_checks++;
    if (status_q !== exp_reg || trap_req !== exp_trap) begin
      n_fail++;
      $display("FAIL %s: status=%h trap=%b expected status=%h trap=%b",
               tag, status_q, trap_req, exp_reg, exp_trap);
    end
  endtask

  // drive one cycle, step the reference model, check after the edge
  task automatic step(input logic w, input logic [31:0] wd, input logic c,
                      input logic u, input logic [4:0] f, input string tag);
    logic [31:0] n;
    logic [4:0]  m;
    logic        t;
    @(negedge clk);
    wr_en = w; wr_data = wd; clr_ttype = c; upd_valid = u; upd_flags = f;
    n = exp_reg; t = 1'b0;
    if (w) n = wd;
    else begin
      if (c) n[16:14] = 3'b000;
      if (u && f != 5'b0) begin
        m = f & exp_reg[27:23];
        if (m != 5'b0) begin
          n[4:0] = top_bit(m); n[16:14] = 3'b001; t = 1'b1;
        end else begin
          n[4:0] = f; n[9:5] = exp_reg[9:5] | f;
        end
      end
    end
    @(posedge clk); #1;
    exp_reg = n; exp_trap = t;
    check(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1; exp_reg = '0; exp_trap = 0;
    check("R1 reset value");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1; check("R1 after reset");

    // non-trapping accrual with no enables
    step(0, 0, 0, 1, 5'b00001, "R4 inexact accrues");
    step(0, 0, 0, 1, 5'b01100, "R4 accrued ORs, current overwritten");
    step(0, 0, 0, 1, 5'b00000, "R7 zero flags no change");
    // enable overflow and divzero (bits 26 and 24)
    step(1, 32'h0500_0000, 0, 0, 0, "R8 write enables");
    step(0, 0, 0, 1, 5'b11111, "R5 overflow picked over lower, R2 order");
    step(0, 0, 0, 0, 0, "R3 trap is one cycle");
    step(0, 0, 0, 1, 5'b00011, "R5 divzero picked, invalid not enabled");
    step(0, 0, 1, 0, 0, "R9 clear trap type");
    step(0, 0, 0, 1, 5'b10101, "R3 no enabled flag, no trap");
    step(1, 32'h0F80_0000, 0, 1, 5'b10000, "R8 write beats update");
    step(0, 0, 1, 1, 5'b10001, "R9 trap with clear leaves 001, R6");
    step(0, 0, 0, 1, 5'b00000, "R7 zero flags keep trap type");
    step(1, 32'hA5A5_5A5A, 1, 1, 5'b11111, "R8 write overrides clear and update");
    step(1, 32'h0000_0000, 0, 0, 0, "R8 write zeros");

    for (int k = 0; k < 400; k++) begin
      logic w, c, u;
      logic [31:0] wd;
      logic [4:0]  f;
      w  = ($urandom % 8) == 0;
      c  = ($urandom % 6) == 0;
      u  = ($urandom % 3) != 0;
      f  = ($urandom % 4 == 0) ? 5'b0 : 5'($urandom);
      wd = $urandom;
      step(w, wd, c, u, f, "R3 R4 R5 R6 random mix");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule